// File: doc/BRIEF.md
# Chip-Select-Gated Memory Command Register

This block is the command and address register that sits on a registered memory module between the controller and the memory devices. On each rising clock edge it captures a data bus together with three control bits: on-die termination, clock enable and a chip select. The data lanes are gated. When both active-low select inputs are high at an edge, the data outputs keep their value. The control bits are not gated and load on every edge.

Two static configuration inputs pick the output arrangement. In the wide layout, all 25 data lanes are registered one to one. In the split layout, a 14-bit word is registered and each bit drives two output copies (A and B), and so do the three control bits. The split layout has two variants. Variant A takes its word from data lanes 0..13. Variant B takes it from lanes 11..24. The alternate select high with the split select low is an illegal combination and gives the wide layout.

An active-low reset clears every register at once and drives every output low. Release from reset passes through a two-stage synchroniser, so the first capture happens on a clean edge. The configuration inputs may change only while reset is asserted.

Top module: `memcmd_register`

## Requirements
- R1: At a rising edge where `dcs_n` or `csr_n` is low, `q_a` shows the selected data word after that edge.
- R2: At a rising edge where `dcs_n` and `csr_n` are both high, `q_a` and `q_b` keep their previous values.
- R3: `odt_a` and `cke_a` load `odt_in` and `cke_in` on every rising edge, whatever the select inputs are.
- R4: `cs_a_n` loads `dcs_n` on every rising edge, and `csr_n` has no effect on it.
- R5: While `rst_n` is low, every output is 0. This takes effect without waiting for a clock edge and overrides the select gating.
- R6: After `rst_n` rises between edges, the outputs stay 0 through the next two rising edges. The third rising edge performs the first capture.
- R7: With `cfg_split`=0 and `cfg_alt`=0 (wide layout), `q_a[24:0]` equals data lanes 24..0, and `q_b`, `odt_b`, `cke_b` and `cs_b_n` are 0.
- R8: With `cfg_split`=1 and `cfg_alt`=0 (split A), the word is `d_in[13:0]`. It appears on both `q_a[13:0]` and `q_b[13:0]`, and `q_a[24:14]` is 0. `odt_b`, `cke_b` and `cs_b_n` copy their A outputs.
- R9: With `cfg_split`=1 and `cfg_alt`=1 (split B), the word is `d_in[24:11]`. It is placed as in R8.
- R10: With `cfg_split`=0 and `cfg_alt`=1, the block behaves exactly as in the wide layout of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| cfg_split | input | 1 | 0: wide 1:1 layout, 1: split 1:2 layout |
| cfg_alt | input | 1 | Chooses split variant B when high |
| dcs_n | input | 1 | Active-low data chip select, also registered to the cs outputs |
| csr_n | input | 1 | Second active-low select that gates data only |
| d_in | input | 25 | Data lanes |
| odt_in | input | 1 | Termination control bit |
| cke_in | input | 1 | Clock enable bit |
| q_a | output | 25 | Data outputs, A copy |
| q_b | output | 14 | Data outputs, B copy (split layout only) |
| odt_a | output | 1 | Registered termination, A copy |
| odt_b | output | 1 | Registered termination, B copy |
| cke_a | output | 1 | Registered clock enable, A copy |
| cke_b | output | 1 | Registered clock enable, B copy |
| cs_a_n | output | 1 | Registered chip select, A copy |
| cs_b_n | output | 1 | Registered chip select, B copy |

## Verification
One table of eight vectors is replayed in all four configuration settings. The vectors cover all four combinations of the two selects. Vectors with both selects high sit between vectors with a select low, and their data patterns differ from their neighbours', so a hold shows up as a mismatch against fresh data. The data patterns set bits both inside and outside the overlap of lanes 0..13 and 11..24. This makes variant A, variant B and the wide layout give different words, so a wrong lane slice or a wrong illegal-combination decode is caught. Cases with `csr_n` low and `dcs_n` high show that the data loads while the registered chip select still follows only `dcs_n`. Each reset is asserted between edges with live data present, which tests that clearing is immediate. The edges around the release are then counted to check the latency of the synchroniser.

// File: rtl/memcmd_pkg.sv
package memcmd_pkg;

    localparam int WIDE_W  = 25;
    localparam int SPLIT_W = 14;

    typedef enum logic [1:0] {
        LAYOUT_WIDE    = 2'd0,
        LAYOUT_SPLIT_A = 2'd1,
        LAYOUT_SPLIT_B = 2'd2
    } layout_e;

    typedef struct packed {
        logic odt;
        logic cke;
        logic cs_n;
    } ctrl_t;

    // split low always means wide; alt only matters in split layout
    function automatic layout_e decode_layout(input logic split, input logic alt);
        if (!split)
            return LAYOUT_WIDE;
        else if (alt)
            return LAYOUT_SPLIT_B;
        else
            return LAYOUT_SPLIT_A;
    endfunction

endpackage

// File: rtl/memcmd_rst_sync.sv
module memcmd_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic run_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign run_n = chain_q[STAGES-1];

    // R6
    release_delay_chk: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> !run_n);
endmodule

// File: rtl/memcmd_capture.sv
module memcmd_capture
    import memcmd_pkg::*;
#(
    parameter int DATA_W = WIDE_W,
    parameter int HALF_W = SPLIT_W
) (
    input  logic              clk,
    input  logic              run_n,
    input  layout_e           layout,
    input  logic [DATA_W-1:0] d_in,
    input  logic              dcs_n,
    input  logic              csr_n,
    input  logic              odt_in,
    input  logic              cke_in,
    output logic [DATA_W-1:0] word_q,
    output ctrl_t             ctrl_q
);
    localparam int PAD_W = DATA_W - HALF_W;

    logic [DATA_W-1:0] sel_word;
    logic              load_en;

    always_comb begin
        unique case (layout)
            LAYOUT_SPLIT_A: sel_word = {{PAD_W{1'b0}}, d_in[HALF_W-1:0]};
            LAYOUT_SPLIT_B: sel_word = {{PAD_W{1'b0}}, d_in[DATA_W-1 -: HALF_W]};
            default:        sel_word = d_in;
        endcase
    end

    assign load_en = !(dcs_n && csr_n);

    always_ff @(posedge clk or negedge run_n) begin
        if (!run_n)
            word_q <= '0;
        else if (load_en)
            word_q <= sel_word;
    end

    always_ff @(posedge clk or negedge run_n) begin
        if (!run_n)
            ctrl_q <= '0;
        else begin
            ctrl_q.odt  <= odt_in;
            ctrl_q.cke  <= cke_in;
            ctrl_q.cs_n <= dcs_n;
        end
    end

    // R2
    gated_hold_chk: assert property (@(posedge clk) disable iff (!run_n)
        (dcs_n && csr_n) |=> $stable(word_q));

    // R1
    gated_load_chk: assert property (@(posedge clk) disable iff (!run_n)
        (!dcs_n || !csr_n) |=> (word_q == $past(sel_word)));

    // R3
    ctrl_follow_chk: assert property (@(posedge clk) disable iff (!run_n)
        1'b1 |=> (ctrl_q.odt == $past(odt_in) && ctrl_q.cke == $past(cke_in)));

    // R4
    cs_follow_chk: assert property (@(posedge clk) disable iff (!run_n)
        1'b1 |=> (ctrl_q.cs_n == $past(dcs_n)));
endmodule

// File: rtl/memcmd_fanout.sv
module memcmd_fanout
    import memcmd_pkg::*;
#(
    parameter int DATA_W = WIDE_W,
    parameter int HALF_W = SPLIT_W
) (
    input  layout_e           layout,
    input  logic [DATA_W-1:0] word_q,
    input  ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] q_a,
    output logic [HALF_W-1:0] q_b,
    output ctrl_t             ctrl_a,
    output ctrl_t             ctrl_b
);
    logic split_on;

    assign split_on = (layout != LAYOUT_WIDE);
    assign q_a      = word_q;
    assign ctrl_a   = ctrl_q;

    for (genvar i = 0; i < HALF_W; i++) begin : g_dup
        assign q_b[i] = split_on & word_q[i];
    end

    assign ctrl_b = split_on ? ctrl_q : '0;
endmodule

// File: rtl/memcmd_register.sv
module memcmd_register
    import memcmd_pkg::*;
#(
    parameter int DATA_W = WIDE_W,
    parameter int HALF_W = SPLIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_split,
    input  logic              cfg_alt,
    input  logic              dcs_n,
    input  logic              csr_n,
    input  logic [DATA_W-1:0] d_in,
    input  logic              odt_in,
    input  logic              cke_in,
    output logic [DATA_W-1:0] q_a,
    output logic [HALF_W-1:0] q_b,
    output logic              odt_a,
    output logic              odt_b,
    output logic              cke_a,
    output logic              cke_b,
    output logic              cs_a_n,
    output logic              cs_b_n
);
    logic              run_n;
    layout_e           layout;
    logic [DATA_W-1:0] word_q;
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_a;
    ctrl_t             ctrl_b;

    assign layout = decode_layout(cfg_split, cfg_alt);

    memcmd_rst_sync #(.STAGES(2)) u_rst_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .run_n (run_n)
    );

    memcmd_capture #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_capture (
        .clk    (clk),
        .run_n  (run_n),
        .layout (layout),
        .d_in   (d_in),
        .dcs_n  (dcs_n),
        .csr_n  (csr_n),
        .odt_in (odt_in),
        .cke_in (cke_in),
        .word_q (word_q),
        .ctrl_q (ctrl_q)
    );

    memcmd_fanout #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_fanout (
        .layout (layout),
        .word_q (word_q),
        .ctrl_q (ctrl_q),
        .q_a    (q_a),
        .q_b    (q_b),
        .ctrl_a (ctrl_a),
        .ctrl_b (ctrl_b)
    );

    assign odt_a  = ctrl_a.odt;
    assign cke_a  = ctrl_a.cke;
    assign cs_a_n = ctrl_a.cs_n;
    assign odt_b  = ctrl_b.odt;
    assign cke_b  = ctrl_b.cke;
    assign cs_b_n = ctrl_b.cs_n;

    // R5
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (q_a == '0 && q_b == '0 && !odt_a && !odt_b &&
                    !cke_a && !cke_b && !cs_a_n && !cs_b_n));

    // R7
    wide_bcopy_low_chk: assert property (@(posedge clk) disable iff (!run_n)
        !cfg_split |-> (q_b == '0 && !odt_b && !cke_b && !cs_b_n));

    // R8
    split_dup_chk: assert property (@(posedge clk) disable iff (!run_n)
        cfg_split |-> (q_b == q_a[HALF_W-1:0] && q_a[DATA_W-1:HALF_W] == '0 &&
                       odt_b == odt_a && cke_b == cke_a && cs_b_n == cs_a_n));
endmodule

// File: tb/memcmd_register_tb.sv
module memcmd_register_tb;
    localparam int DW = 25;
    localparam int HW = 14;
    localparam int NV = 8;

    // vector layout: {dcs_n, csr_n, odt, cke, data[24:0]}
    localparam logic [28:0] VECS [NV] = '{
        {1'b0, 1'b0, 1'b1, 1'b0, 25'h1ABCDEF},
        {1'b1, 1'b1, 1'b0, 1'b1, 25'h0123456},
        {1'b1, 1'b0, 1'b1, 1'b1, 25'h1555555},
        {1'b0, 1'b1, 1'b0, 1'b0, 25'h0AAAAAA},
        {1'b1, 1'b1, 1'b1, 1'b0, 25'h1FFFFFF},
        {1'b1, 1'b1, 1'b0, 1'b1, 25'h0000001},
        {1'b0, 1'b0, 1'b1, 1'b1, 25'h1000800},
        {1'b1, 1'b0, 1'b0, 1'b0, 25'h07FFF00}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_split = 1'b0;
    logic          cfg_alt = 1'b0;
    logic          dcs_n = 1'b1;
    logic          csr_n = 1'b1;
    logic [DW-1:0] d_in = '0;
    logic          odt_in = 1'b0;
    logic          cke_in = 1'b0;
    logic [DW-1:0] q_a;
    logic [HW-1:0] q_b;
    logic          odt_a, odt_b, cke_a, cke_b, cs_a_n, cs_b_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] m_word;
    logic          m_odt, m_cke, m_cs;

    always #5 clk = ~clk;

    memcmd_register u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_split(cfg_split), .cfg_alt(cfg_alt),
        .dcs_n(dcs_n), .csr_n(csr_n), .d_in(d_in), .odt_in(odt_in),
        .cke_in(cke_in), .q_a(q_a), .q_b(q_b), .odt_a(odt_a), .odt_b(odt_b),
        .cke_a(cke_a), .cke_b(cke_b), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n)
    );

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pick(input logic [DW-1:0] d);
        if (!cfg_split)   return d;
        else if (cfg_alt) return {{(DW-HW){1'b0}}, d[DW-1 -: HW]};
        else              return {{(DW-HW){1'b0}}, d[HW-1:0]};
    endfunction

    task automatic check_model(input string rq_data, input string rq_lay);
        logic s;
        s = cfg_split;
        chk(rq_data, "q_a",    32'(q_a),    32'(m_word));
        chk(rq_lay,  "q_b",    32'(q_b),    s ? 32'(m_word[HW-1:0]) : 32'd0);
        chk("R3",    "odt_a",  32'(odt_a),  32'(m_odt));
        chk("R3",    "cke_a",  32'(cke_a),  32'(m_cke));
        chk("R4",    "cs_a_n", 32'(cs_a_n), 32'(m_cs));
        chk(rq_lay,  "odt_b",  32'(odt_b),  32'(s & m_odt));
        chk(rq_lay,  "cke_b",  32'(cke_b),  32'(s & m_cke));
        chk(rq_lay,  "cs_b_n", 32'(cs_b_n), 32'(s & m_cs));
    endtask

    task automatic check_zero(input string rq);
        chk(rq, "all outputs", {q_a, q_b, odt_a, odt_b, cke_a, cke_b, cs_a_n, cs_b_n} == '0, 32'd1);
    endtask

    task automatic reset_phase(input logic split, input logic alt, input string rq_lay);
        @(negedge clk);
        #2;
        rst_n = 1'b0;               // mid-cycle, select low, live data
        dcs_n = 1'b0; csr_n = 1'b0; d_in = 25'h1E3C5A7; odt_in = 1'b1; cke_in = 1'b1;
        #1;
        check_zero("R5");           // cleared before any edge
        cfg_split = split;
        cfg_alt = alt;
        @(negedge clk);
        @(negedge clk);
        check_zero("R5");
        rst_n = 1'b1;
        @(negedge clk);
        check_zero("R6");           // first edge after release
        @(negedge clk);
        check_zero("R6");           // second edge after release
        m_word = pick(d_in); m_odt = 1'b1; m_cke = 1'b1; m_cs = 1'b0;
        @(negedge clk);
        check_model("R6", rq_lay);  // third edge captures
    endtask

    task automatic run_table(input string rq_lay);
        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VECS[i];
            dcs_n = v[28]; csr_n = v[27]; odt_in = v[26]; cke_in = v[25]; d_in = v[24:0];
            @(negedge clk);
            if (!(v[28] && v[27])) m_word = pick(v[24:0]);
            m_odt = v[26]; m_cke = v[25]; m_cs = v[28];
            check_model((v[28] && v[27]) ? "R2" : "R1", rq_lay);
        end
    endtask

    initial begin
        reset_phase(1'b0, 1'b0, "R7");
        run_table("R7");
        reset_phase(1'b1, 1'b0, "R8");
        run_table("R8");
        reset_phase(1'b1, 1'b1, "R9");
        run_table("R9");
        reset_phase(1'b0, 1'b1, "R10");
        run_table("R10");
        // R2 hold across several idle edges with changing data
        dcs_n = 1'b1; csr_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            d_in = 25'(k * 25'h0F0F0F + 1);
            odt_in = k[0]; cke_in = ~k[0];
            @(negedge clk);
            m_odt = k[0]; m_cke = ~k[0]; m_cs = 1'b1;
            check_model("R2", "R10");
        end
        // final reset with both selects high: still clears (R5)
        #2;
        rst_n = 1'b0;
        #1;
        check_zero("R5");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule